// File: doc/BRIEF.md
# Unary Byte Function Unit

This block takes one byte and a 4-bit operation code and produces one transformed byte. The sixteen operations are:

- stepping by one or by two, up or down;
- bitwise inversion and arithmetic negation;
- single-bit rotates and shifts in both directions, with a sign-keeping right shift among them;
- moves of a whole nibble with a zero or sign fill;
- exchange of the two nibbles;
- a pass-through.

No flags are produced and no carry is consumed.

A caller presents the byte and the code together with a one-cycle valid strobe. On the next clock edge the result is captured into the output register, and a done pulse marks that cycle. The output then holds until the next strobe. Strobes may arrive on consecutive cycles, and each one yields its own result and its own done cycle.

Sequencing uses a two-state controller:
- `ST_IDLE`: no result was captured on the last edge.
- `ST_EMIT`: a result was captured on the last edge, and done is high.

The transitions are:
- `IDLE->EMIT` on a strobe.
- `EMIT->EMIT` on a further strobe.
- `EMIT->IDLE` when no strobe is present.
- `IDLE->IDLE` otherwise.

Reset puts the controller in `ST_IDLE` and clears the output byte.

Top module: `ubyte_fn_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, out_data is 0x00 and out_done is 0.
- R2: out_done is 1 in exactly those cycles that directly follow a clock edge where in_valid was 1. Every strobe gives one done cycle, including strobes on consecutive cycles.
- R3: When in_valid is 0, in_sel and in_data have no effect: out_data keeps its last value.
- R4: Codes 0, 1, 2 and 3 give x+1, x-1, x+2 and x-2 modulo 256. For example, 0xFF with code 2 gives 0x01, and 0x00 with code 3 gives 0xFE.
- R5: Code 4 gives the bitwise inverse of x. Code 5 gives the inverse plus one, modulo 256, so 0x00 gives 0x00 and 0x80 gives 0x80.
- R6: Code 6 rotates right by one: bit 0 moves to bit 7. Code 7 rotates left by one: bit 7 moves to bit 0.
- R7: Code 8 shifts right by one and fills bit 7 with 0. Code 9 shifts left by one and fills bit 0 with 0. Code 10 shifts right by one and keeps bit 7 at its old value.
- R8: Code 11 places bits 7:4 of x in bits 3:0 and fills bits 7:4 with copies of bit 7 of x.
- R9: Code 12 places bits 7:4 in bits 3:0 with bits 7:4 zero. Code 13 places bits 3:0 in bits 7:4 with bits 3:0 zero.
- R10: Code 14 exchanges bits 7:4 and bits 3:0.
- R11: Code 15 returns x unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture a result on this edge |
| in_sel | input | 4 | Operation code 0..15 |
| in_data | input | 8 | Operand byte |
| out_data | output | 8 | Registered result |
| out_done | output | 1 | High for the cycle after each strobe |

## Verification
The hardest case to reach from the ports is a run of strobes on consecutive cycles. In that case the controller stays in `ST_EMIT`, done never falls, and each output value has to be matched to the correct earlier operand. The stimulus sends long back-to-back bursts driven by a shift-register sequence. Between the bursts it leaves idle gaps in which the code and the operand keep changing with the strobe low. A queue of expected results is consumed only on done cycles, so a lost, doubled or misaligned capture shows up as a wrong value or a wrong queue length.

// File: rtl/ufu_pkg.sv
package ufu_pkg;
    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_INC1 = 4'd0,
        OP_DEC1 = 4'd1,
        OP_INC2 = 4'd2,
        OP_DEC2 = 4'd3,
        OP_NOT  = 4'd4,
        OP_NEG  = 4'd5,
        OP_ROTR = 4'd6,
        OP_ROTL = 4'd7,
        OP_SHR  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SAR  = 4'd10,
        OP_SAR4 = 4'd11,
        OP_SHR4 = 4'd12,
        OP_SHL4 = 4'd13,
        OP_SWAP = 4'd14,
        OP_PASS = 4'd15
    } ufu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ufu_state_e;
endpackage

// File: rtl/ufu_arith.sv
module ufu_arith #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_in,
    output logic [DATA_W-1:0] inc1_o,
    output logic [DATA_W-1:0] dec1_o,
    output logic [DATA_W-1:0] inc2_o,
    output logic [DATA_W-1:0] dec2_o,
    output logic [DATA_W-1:0] inv_o,
    output logic [DATA_W-1:0] neg_o
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] TWO = {{(DATA_W-2){1'b0}}, 2'b10};

    always_comb begin
        inc1_o = op_in + ONE;
        dec1_o = op_in - ONE;
        inc2_o = op_in + TWO;
        dec2_o = op_in - TWO;
        inv_o  = ~op_in;
        neg_o  = inv_o + ONE;
    end
endmodule

// File: rtl/ufu_shift.sv
module ufu_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_in,
    output logic [DATA_W-1:0] rotr_o,
    output logic [DATA_W-1:0] rotl_o,
    output logic [DATA_W-1:0] shr_o,
    output logic [DATA_W-1:0] shl_o,
    output logic [DATA_W-1:0] sar_o
);
    localparam int unsigned MSB = DATA_W - 1;

    always_comb begin
        rotr_o = {op_in[0], op_in[MSB:1]};
        rotl_o = {op_in[MSB-1:0], op_in[MSB]};
        shr_o  = {1'b0, op_in[MSB:1]};
        shl_o  = {op_in[MSB-1:0], 1'b0};
        sar_o  = {op_in[MSB], op_in[MSB:1]};
    end
endmodule

// File: rtl/ufu_nibble.sv
module ufu_nibble #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_in,
    output logic [DATA_W-1:0] sar4_o,
    output logic [DATA_W-1:0] shr4_o,
    output logic [DATA_W-1:0] shl4_o,
    output logic [DATA_W-1:0] swap_o
);
    localparam int unsigned HALF = DATA_W / 2;
    localparam int unsigned MSB  = DATA_W - 1;

    logic [HALF-1:0] hi_n;
    logic [HALF-1:0] lo_n;

    always_comb begin
        hi_n   = op_in[MSB:HALF];
        lo_n   = op_in[HALF-1:0];
        sar4_o = {{HALF{op_in[MSB]}}, hi_n};
        shr4_o = {{HALF{1'b0}}, hi_n};
        shl4_o = {lo_n, {HALF{1'b0}}};
        swap_o = {lo_n, hi_n};
    end
endmodule

// File: rtl/ubyte_fn_unit.sv
module ubyte_fn_unit
    import ufu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_done
);
    localparam int unsigned HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] FOUR = {{(DATA_W-3){1'b0}}, 3'b100};

    logic [DATA_W-1:0] inc1_w, dec1_w, inc2_w, dec2_w, inv_w, neg_w;
    logic [DATA_W-1:0] rotr_w, rotl_w, shr_w, shl_w, sar_w;
    logic [DATA_W-1:0] sar4_w, shr4_w, shl4_w, swap_w;
    logic [DATA_W-1:0] pick_w;
    logic [DATA_W-1:0] result_q;
    ufu_op_e           op_w;
    ufu_state_e        state_q, state_d;

    ufu_arith #(.DATA_W(DATA_W)) u_arith (
        .op_in (in_data),
        .inc1_o(inc1_w),
        .dec1_o(dec1_w),
        .inc2_o(inc2_w),
        .dec2_o(dec2_w),
        .inv_o (inv_w),
        .neg_o (neg_w)
    );

    ufu_shift #(.DATA_W(DATA_W)) u_shift (
        .op_in (in_data),
        .rotr_o(rotr_w),
        .rotl_o(rotl_w),
        .shr_o (shr_w),
        .shl_o (shl_w),
        .sar_o (sar_w)
    );

    ufu_nibble #(.DATA_W(DATA_W)) u_nibble (
        .op_in (in_data),
        .sar4_o(sar4_w),
        .shr4_o(shr4_w),
        .shl4_o(shl4_w),
        .swap_o(swap_w)
    );

    // Operation select
    always_comb begin
        op_w = ufu_op_e'(in_sel);
        unique case (op_w)
            OP_INC1: pick_w = inc1_w;
            OP_DEC1: pick_w = dec1_w;
            OP_INC2: pick_w = inc2_w;
            OP_DEC2: pick_w = dec2_w;
            OP_NOT:  pick_w = inv_w;
            OP_NEG:  pick_w = neg_w;
            OP_ROTR: pick_w = rotr_w;
            OP_ROTL: pick_w = rotl_w;
            OP_SHR:  pick_w = shr_w;
            OP_SHL:  pick_w = shl_w;
            OP_SAR:  pick_w = sar_w;
            OP_SAR4: pick_w = sar4_w;
            OP_SHR4: pick_w = shr4_w;
            OP_SHL4: pick_w = shl4_w;
            OP_SWAP: pick_w = swap_w;
            OP_PASS: pick_w = in_data;
            default: pick_w = in_data;
        endcase
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= pick_w;
        end
    end

    assign out_data = result_q;
    assign out_done = (state_q == ST_EMIT);

    // R2
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    // R2
    done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R4
    step_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc2_w - dec2_w) == FOUR);

    // R5
    neg_vs_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_w - inv_w) == ONE);

    // R6
    rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rotr_w) == $countones(in_data));

    // R8
    sar4_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sar4_w[HALF-1:0] == shr4_w[HALF-1:0]);

    // R10
    swap_parts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_w == (shr4_w | shl4_w));
endmodule

// File: tb/ubyte_fn_unit_tb.sv
`timescale 1ns/1ps
module ubyte_fn_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_sel = 4'd0;
    logic [7:0] in_data = 8'd0;
    logic [7:0] out_data;
    logic       out_done;

    int unsigned errors = 0;
    int unsigned checks = 0;
    bit          mon_on = 1'b0;
    bit          finished = 1'b0;
    logic        valid_d = 1'b0;
    logic [7:0]  last_out = 8'd0;
    logic [19:0] sb_q[$];

    always #2 clk = ~clk;

    ubyte_fn_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
        .in_data(in_data), .out_data(out_data), .out_done(out_done)
    );

    function automatic logic [7:0] model(input logic [3:0] s, input logic [7:0] d);
        case (s)
            4'd0:  return d + 8'd1;
            4'd1:  return d - 8'd1;
            4'd2:  return d + 8'd2;
            4'd3:  return d - 8'd2;
            4'd4:  return ~d;
            4'd5:  return (~d) + 8'd1;
            4'd6:  return {d[0], d[7:1]};
            4'd7:  return {d[6:0], d[7]};
            4'd8:  return {1'b0, d[7:1]};
            4'd9:  return {d[6:0], 1'b0};
            4'd10: return {d[7], d[7:1]};
            4'd11: return {{4{d[7]}}, d[7:4]};
            4'd12: return {4'h0, d[7:4]};
            4'd13: return {d[3:0], 4'h0};
            4'd14: return {d[3:0], d[7:4]};
            default: return d;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] s);
        case (s)
            4'd0, 4'd1, 4'd2, 4'd3: return "R4";
            4'd4, 4'd5:             return "R5";
            4'd6, 4'd7:             return "R6";
            4'd8, 4'd9, 4'd10:      return "R7";
            4'd11:                  return "R8";
            4'd12, 4'd13:           return "R9";
            4'd14:                  return "R10";
            default:                return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_sel   = s;
        in_data  = d;
        sb_q.push_back({s, d, model(s, d)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sel   = in_sel + 4'd5;
            in_data  = in_data ^ 8'h6B;
        end
    endtask

    always @(posedge clk) valid_d <= rst_n ? in_valid : 1'b0;

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                check(out_done == valid_d, "R2", {7'd0, out_done}, {7'd0, valid_d});
                if (out_done) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R2", out_data, 8'h00);
                    end else begin
                        logic [19:0] item;
                        item = sb_q.pop_front();
                        check(out_data == item[7:0], tag(item[19:16]), out_data, item[7:0]);
                    end
                end else begin
                    check(out_data == last_out, "R3", out_data, last_out);
                end
                last_out = out_data;
            end
        end
    end

    initial begin
        logic [7:0] lfsr;
        logic [7:0] pats [14];
        pats = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFE,
                 8'hFF, 8'h0F, 8'hF0, 8'hA5, 8'h5A, 8'h3C, 8'hC3};
        repeat (3) @(negedge clk);
        // R1: during reset
        check(out_data == 8'h00, "R1", out_data, 8'h00);
        check(out_done == 1'b0, "R1", {7'd0, out_done}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_data == 8'h00, "R1", out_data, 8'h00);
        check(out_done == 1'b0, "R1", {7'd0, out_done}, 8'h00);
        last_out = 8'h00;
        mon_on = 1'b1;

        // Named boundaries: R4 wrap, R5 zero and 0x80, R7 sign fill
        apply(4'd2, 8'hFF); idle(2);
        apply(4'd3, 8'h00); idle(1);
        apply(4'd5, 8'h00); apply(4'd5, 8'h80);
        apply(4'd10, 8'h80); idle(3);

        // Every code against every pattern, one at a time with gaps
        for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 14; p++) begin
                apply(s[3:0], pats[p]);
                idle(1 + (p % 3));
            end
        end

        // Back-to-back bursts with pseudo-random operands
        lfsr = 8'hB7;
        for (int b = 0; b < 20; b++) begin
            for (int k = 0; k < 12; k++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                apply(lfsr[3:0] ^ k[3:0], lfsr);
            end
            idle(4);
        end
        idle(4);

        // R2: every strobe consumed exactly once
        check(sb_q.size() == 0, "R2", 8'(sb_q.size()), 8'h00);
        mon_on = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule